// File: doc/BRIEF.md
# MDIO Management Bus Master

This block runs clause-22 style read and write transactions with external PHY devices over a two-wire management bus. It divides the system clock into a management clock (MDC). It serialises the complete frame onto the data line, and for reads it returns the line to the PHY at the turnaround. It then captures the sixteen reply bits and reports whether the PHY answered with the expected low turnaround bit.

A host issues one command at a time through a valid/ready handshake: PHY address, register number, a write select and write data. `cmd_ready` is simply the inverse of `busy`, so back-pressure lasts for the whole frame. A command presented while the engine is busy is not accepted and has no effect. At the end of every frame a one-cycle `rsp_valid` pulse marks the result. The result has no ready signal: `rsp_rdata` and `rsp_ta_err` hold their values until the next completion, so a host can read them at any later time.

The data line is split into `mdio_o`, `mdio_oe` and `mdio_i` for the pad ring. The engine changes the driven value when MDC falls and samples the input when MDC rises.

Top module: `mdio_master`

## Requirements
- R1: After reset `busy`=0, `cmd_ready`=1, `mdc`=0, `mdio_oe`=0 and `rsp_valid`=0.
- R2: `mdc` stays low while idle. While busy it toggles every `DIV_HALF` system clocks, so it has a period of 2*`DIV_HALF` clocks, and its first rise comes `DIV_HALF` clocks after the command is accepted.
- R3: Bit positions are counted from 0 at successive MDC rising edges. Positions 0..31 are driven 1 and positions 32,33 are driven 0,1.
- R4: Positions 34,35 carry the operation code. A read sends 1,0 and a write sends 0,1.
- R5: Positions 36..40 carry the PHY address and positions 41..45 carry the register number, each most significant bit first. Positions 0..45 are always driven (`mdio_oe`=1).
- R6: On a write, positions 46,47 are driven 1,0 and positions 48..63 carry `cmd_wdata` MSB first, all with `mdio_oe`=1.
- R7: On a read, `mdio_oe`=0 from position 46 through 63. `mdio_i` is sampled at the rising edges of positions 48..63 and the sixteen values are returned MSB first in `rsp_rdata`.
- R8: On a read, `rsp_ta_err`=1 exactly when `mdio_i` is high at the rising edge of position 47. On a write, `rsp_ta_err`=0 and `rsp_rdata`=0.
- R9: Position 64 is an idle bit with `mdio_oe`=0. `busy` is high for exactly 65*2*`DIV_HALF` clocks. `rsp_valid` is high for one cycle, starting at the edge where `busy` falls.
- R10: A command is accepted only when `cmd_valid` and `cmd_ready` are both high, and `cmd_ready` is low while busy. `cmd_valid` asserted during a frame does not change the frame and does not start a further one.
- R11: `rsp_rdata` and `rsp_ta_err` change only at a completion and stay stable until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine can take a command (not busy) |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 5 | Register number within the PHY |
| cmd_wdata | input | 16 | Data for a write |
| busy | output | 1 | Frame in progress |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Data read back (0 after a write) |
| rsp_ta_err | output | 1 | PHY did not pull the turnaround bit low |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Value driven onto the data line |
| mdio_oe | output | 1 | Drive enable for the data line |
| mdio_i | input | 1 | Value seen on the data line |

## Verification
The bench records every bit and drive enable at each MDC rise and compares them with a frame it builds itself. A design that shifted the address LSB first, swapped the opcodes or held the line during a read turnaround would show up as a mismatched position. Read replies use patterns with only the top or only the bottom bit set, which expose off-by-one sampling that drops or duplicates an edge bit. A read where the model leaves the turnaround bit high must raise the error flag, and a read with a proper low bit must not. A command thrown in mid-frame must leave the frame untouched and must not start a second frame, which catches a design that reloads on any valid.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_BITS   = 32;
  localparam int ST_IDX     = PRE_BITS;
  localparam int OP_IDX     = ST_IDX + 2;
  localparam int PHY_IDX    = OP_IDX + 2;
  localparam int REG_IDX    = PHY_IDX + 5;
  localparam int TA_IDX     = REG_IDX + 5;
  localparam int DATA_IDX   = TA_IDX + 2;
  localparam int IDLE_IDX   = DATA_IDX + 16;
  localparam int FRAME_BITS = IDLE_IDX + 1;
  localparam int IDXW       = $clog2(FRAME_BITS);

  // element FRAME_BITS-1 leaves first
  typedef logic [FRAME_BITS-1:0] frame_t;

  typedef enum logic {SEQ_IDLE, SEQ_RUN} seq_state_t;

  function automatic frame_t frame_value(input logic wr, input logic [4:0] phy,
                                         input logic [4:0] rg, input logic [15:0] wd);
    frame_t f;
    f = '0;
    for (int p = 0; p < FRAME_BITS; p++) begin
      logic b;
      b = 1'b0;
      if (p < ST_IDX)             b = 1'b1;
      else if (p == ST_IDX + 1)   b = 1'b1;
      else if (p == OP_IDX)       b = ~wr;
      else if (p == OP_IDX + 1)   b = wr;
      else if (p >= PHY_IDX && p < REG_IDX)  b = phy[4 - (p - PHY_IDX)];
      else if (p >= REG_IDX && p < TA_IDX)   b = rg[4 - (p - REG_IDX)];
      else if (p == TA_IDX)       b = wr;
      else if (p >= DATA_IDX && p < IDLE_IDX) b = wr & wd[15 - (p - DATA_IDX)];
      f[FRAME_BITS-1-p] = b;
    end
    return f;
  endfunction

  function automatic frame_t frame_drive(input logic wr);
    frame_t f;
    f = '0;
    for (int p = 0; p < FRAME_BITS; p++)
      f[FRAME_BITS-1-p] = (p < TA_IDX) || (wr && p < IDLE_IDX);
    return f;
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  logic half_end;

  generate
    if (DIV_HALF <= 1) begin : g_fast
      assign half_end = run;
    end else begin : g_div
      localparam int CW = $clog2(DIV_HALF);
      localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt <= '0;
        else if (!run || cnt == LAST) cnt <= '0;
        else                      cnt <= cnt + 1'b1;
      end
      assign half_end = run && (cnt == LAST);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mdc <= 1'b0;
    else if (!run)     mdc <= 1'b0;
    else if (half_end) mdc <= ~mdc;
  end

  assign rise_tick = half_end && !mdc;
  assign fall_tick = half_end && mdc;
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             wr,
  input  logic [4:0]       phy,
  input  logic [4:0]       rg,
  input  logic [15:0]      wd,
  input  logic             fall_tick,
  output logic             busy,
  output logic             is_read,
  output logic [IDXW-1:0]  bit_idx,
  output logic             done,
  output logic             mdio_o,
  output logic             mdio_oe
);
  seq_state_t state;
  frame_t     tx_sr, oe_sr;

  assign busy = (state == SEQ_RUN);
  assign done = busy && fall_tick && (bit_idx == IDXW'(IDLE_IDX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SEQ_IDLE;
      tx_sr   <= '0;
      oe_sr   <= '0;
      bit_idx <= '0;
      is_read <= 1'b0;
    end else begin
      case (state)
        SEQ_IDLE: if (start) begin
          state   <= SEQ_RUN;
          tx_sr   <= frame_value(wr, phy, rg, wd);
          oe_sr   <= frame_drive(wr);
          bit_idx <= '0;
          is_read <= ~wr;
        end
        SEQ_RUN: if (fall_tick) begin
          if (done) begin
            state <= SEQ_IDLE;
            tx_sr <= '0;
            oe_sr <= '0;
          end else begin
            tx_sr   <= tx_sr << 1;
            oe_sr   <= oe_sr << 1;
            bit_idx <= bit_idx + 1'b1;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  assign mdio_o  = tx_sr[FRAME_BITS-1];
  assign mdio_oe = oe_sr[FRAME_BITS-1];
endmodule

// File: rtl/mdio_rx.sv
module mdio_rx
  import mdio_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            rise_tick,
  input  logic            is_read,
  input  logic [IDXW-1:0] bit_idx,
  input  logic            mdio_i,
  input  logic            done,
  output logic            rsp_valid,
  output logic [15:0]     rsp_rdata,
  output logic            rsp_ta_err
);
  logic [15:0] sh;
  logic        ta_hi;
  logic        in_data;

  assign in_data = (bit_idx >= IDXW'(DATA_IDX)) && (bit_idx < IDXW'(IDLE_IDX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh    <= '0;
      ta_hi <= 1'b0;
    end else if (start) begin
      sh    <= '0;
      ta_hi <= 1'b0;
    end else if (rise_tick && is_read) begin
      if (bit_idx == IDXW'(TA_IDX + 1)) ta_hi <= mdio_i;
      if (in_data)                      sh    <= {sh[14:0], mdio_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      rsp_ta_err <= 1'b0;
    end else begin
      rsp_valid <= done;
      if (done) begin
        rsp_rdata  <= is_read ? sh : 16'h0;
        rsp_ta_err <= is_read & ta_hi;
      end
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic        cmd_write,
  input  logic [4:0]  cmd_phy,
  input  logic [4:0]  cmd_reg,
  input  logic [15:0] cmd_wdata,
  output logic        busy,
  output logic        rsp_valid,
  output logic [15:0] rsp_rdata,
  output logic        rsp_ta_err,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic            start, rise_tick, fall_tick, is_read, done;
  logic [IDXW-1:0] bit_idx;

  assign cmd_ready = ~busy;
  assign start     = cmd_valid & cmd_ready;

  mdio_clkgen #(.DIV_HALF(DIV_HALF)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy),
    .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .wr(cmd_write),
    .phy(cmd_phy), .rg(cmd_reg), .wd(cmd_wdata), .fall_tick(fall_tick),
    .busy(busy), .is_read(is_read), .bit_idx(bit_idx), .done(done),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  mdio_rx u_rx (
    .clk(clk), .rst_n(rst_n), .start(start), .rise_tick(rise_tick),
    .is_read(is_read), .bit_idx(bit_idx), .mdio_i(mdio_i), .done(done),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_ta_err(rsp_ta_err)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic        busy,
  input logic        mdc,
  input logic        mdio_oe,
  input logic        rsp_valid,
  input logic [15:0] rsp_rdata,
  input logic        rsp_ta_err
);
  a_r10_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> busy);
  a_r2_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);
  a_r9_oe_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> busy);
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r9_end_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rsp_valid);
  a_r11_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> ($stable(rsp_rdata) && $stable(rsp_ta_err)));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .busy(busy), .mdc(mdc), .mdio_oe(mdio_oe), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .rsp_ta_err(rsp_ta_err)
);

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
  localparam int DH    = 4;
  localparam int NBITS = 65;
  localparam int NVEC  = 6;
  // {write, phy, reg, wdata, reply data, turnaround answered low}
  localparam logic [43:0] VEC [NVEC] = '{
    {1'b1, 5'd1,  5'd0,  16'hA5C3, 16'h0000, 1'b1},
    {1'b0, 5'd31, 5'd2,  16'h0000, 16'h8000, 1'b1},
    {1'b0, 5'd16, 5'd17, 16'h0000, 16'h0001, 1'b1},
    {1'b1, 5'd0,  5'd31, 16'hFFFF, 16'h0000, 1'b1},
    {1'b0, 5'd5,  5'd9,  16'h0000, 16'h1234, 1'b0},
    {1'b0, 5'd10, 5'd21, 16'h0000, 16'hBEEF, 1'b1}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [4:0] cmd_phy = '0, cmd_reg = '0;
  logic [15:0] cmd_wdata = '0;
  logic mdio_i = 1'b1;
  logic cmd_ready, busy, rsp_valid, rsp_ta_err, mdc, mdio_o, mdio_oe;
  logic [15:0] rsp_rdata;

  mdio_master #(.DIV_HALF(DH)) u_mdio_master (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_phy(cmd_phy), .cmd_reg(cmd_reg),
    .cmd_wdata(cmd_wdata), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_ta_err(rsp_ta_err), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int n_chk = 0, n_fail = 0;
  int nrise = 0, busy_cyc = 0, rspv_cnt = 0, cyc = 0, last_rise = 0, period_bad = 0;
  logic [NBITS-1:0] cap_o, cap_oe, reply;
  logic mdc_q = 1'b0;

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // bus monitor and PHY model
  always @(negedge clk) begin
    cyc++;
    if (mdc && !mdc_q) begin
      if (nrise > 0 && (cyc - last_rise) != 2*DH) period_bad++;
      last_rise = cyc;
      if (nrise < NBITS) begin
        cap_o[nrise]  = mdio_o;
        cap_oe[nrise] = mdio_oe;
      end
      nrise++;
    end
    mdc_q = mdc;
    if (!mdc) mdio_i = (nrise < NBITS) ? reply[nrise] : 1'b1;
    if (busy) busy_cyc++;
    if (rsp_valid) rspv_cnt++;
  end

  task automatic run(input logic [43:0] v, input logic intrude);
    logic wr; logic [4:0] phy, rg; logic [15:0] wd, rd; logic ta_ok;
    logic [NBITS-1:0] eo, eoe;
    logic [15:0] prev_rd; logic prev_err; logic [15:0] got;
    int guard;
    {wr, phy, rg, wd, rd, ta_ok} = v;
    reply = '1;
    if (!wr) begin
      reply[47] = ~ta_ok;
      for (int i = 0; i < 16; i++) reply[48+i] = rd[15-i];
    end
    eo = '0; eoe = '0;
    for (int p = 0; p < NBITS; p++) begin
      eoe[p] = (p < 46) || (wr && p < 64);
      if (p < 32 || p == 33) eo[p] = 1'b1;
    end
    eo[34] = ~wr; eo[35] = wr;
    for (int i = 0; i < 5; i++) begin
      eo[36+i] = phy[4-i];
      eo[41+i] = rg[4-i];
    end
    eo[46] = wr;
    for (int i = 0; i < 16; i++) eo[48+i] = wr & wd[15-i];
    prev_rd = rsp_rdata; prev_err = rsp_ta_err;

    @(negedge clk);
    nrise = 0; busy_cyc = 0; rspv_cnt = 0; period_bad = 0;
    cmd_valid = 1'b1; cmd_write = wr; cmd_phy = phy; cmd_reg = rg; cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy && !cmd_ready, "R10", "busy/not ready after accept", {busy, cmd_ready}, 2'b10);
    for (int i = 1; i < DH; i++) @(negedge clk);
    chk(!mdc, "R2", "mdc low before first half period", mdc, 0);
    @(negedge clk);
    chk(mdc, "R2", "first mdc rise after DIV_HALF", mdc, 1);
    if (intrude) begin
      repeat (40) @(negedge clk);
      cmd_valid = 1'b1; cmd_write = ~wr; cmd_phy = ~phy; cmd_reg = ~rg; cmd_wdata = ~wd;
      repeat (3) @(negedge clk);
      cmd_valid = 1'b0;
    end
    repeat (100) @(negedge clk);
    chk(rsp_rdata == prev_rd && rsp_ta_err == prev_err, "R11", "result held mid-frame",
        {rsp_ta_err, rsp_rdata}, {prev_err, prev_rd});
    guard = 0;
    while (busy && guard < 2000) begin @(negedge clk); guard++; end
    chk(rsp_valid, "R9", "rsp_valid as busy falls", rsp_valid, 1);
    got = rsp_rdata;
    repeat (3) @(negedge clk);
    chk(rspv_cnt == 1, "R9", "single rsp_valid pulse", rspv_cnt, 1);
    chk(busy_cyc == NBITS*2*DH, "R9", "busy length", busy_cyc, NBITS*2*DH);
    chk(nrise == NBITS, "R9", "mdc rising edges per frame", nrise, NBITS);
    chk(period_bad == 0, "R2", "mdc period", period_bad, 0);
    chk(cap_o[33:0] == eo[33:0], "R3", "preamble and start", cap_o[33:0], eo[33:0]);
    chk(cap_o[35:34] == eo[35:34], "R4", "opcode", cap_o[35:34], eo[35:34]);
    chk(cap_o[45:36] == eo[45:36] && cap_oe[45:0] == eoe[45:0], "R5", "address fields",
        {cap_oe[45:36], cap_o[45:36]}, {eoe[45:36], eo[45:36]});
    if (wr) begin
      chk(cap_o[63:46] == eo[63:46] && cap_oe[63:46] == eoe[63:46], "R6", "write turnaround/data",
          {cap_oe[63:46], cap_o[63:46]}, {eoe[63:46], eo[63:46]});
      chk(got == 16'h0 && !rsp_ta_err, "R8", "write result zero", {rsp_ta_err, got}, 0);
    end else begin
      chk(cap_oe[63:46] == '0, "R7", "line released on read", cap_oe[63:46], 0);
      chk(got == rd, "R7", "read data", got, rd);
      chk(rsp_ta_err == ~ta_ok, "R8", "turnaround error flag", rsp_ta_err, ~ta_ok);
    end
    chk(!cap_oe[64], "R9", "idle bit released", cap_oe[64], 0);
    if (intrude) begin
      repeat (30) @(negedge clk);
      chk(!busy && !mdc && nrise == NBITS, "R10", "no frame from ignored start",
          {busy, mdc, 8'(nrise)}, {2'b00, 8'(NBITS)});
    end
  endtask

  logic finished = 1'b0;

  initial begin
    repeat (4) @(negedge clk);
    chk(!busy && cmd_ready && !mdc && !mdio_oe && !rsp_valid, "R1", "reset outputs",
        {busy, cmd_ready, mdc, mdio_oe, rsp_valid}, 5'b01000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !mdc, "R2", "idle mdc low", {busy, mdc}, 0);
    for (int k = 0; k < NVEC; k++) run(VEC[k], 1'b0);
    // directed: start request ignored while busy
    run({1'b1, 5'd3, 5'd4, 16'h5A5A, 16'h0, 1'b1}, 1'b1);
    run({1'b0, 5'd7, 5'd8, 16'h0, 16'hC001, 1'b1}, 1'b1);
    // directed: error flag cleared by a following good read
    run({1'b0, 5'd2, 5'd3, 16'h0, 16'hFFFF, 1'b0}, 1'b0);
    run({1'b0, 5'd2, 5'd3, 16'h0, 16'h7FFE, 1'b1}, 1'b0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule